// File: doc/BRIEF.md
# Supply-Tracking Limiter Threshold Generator

This block turns a sampled supply-voltage word into the threshold that a downstream peak limiter compares against. Each time a new supply sample arrives with its valid strobe, the block captures the sample together with the current configuration and, three clock cycles later, presents a registered threshold word with a one-cycle valid flag. Between updates, the output word holds its last value.

Two curves are available, selected by a mode bit. In tracking mode, the threshold sits at a ceiling value while the supply is healthy. Once the supply sags below a knee voltage, the threshold is reduced by a programmable slope times the shortfall, and it is never allowed below a floor value. In headroom mode, the threshold is the live supply scaled by one minus a signed percentage. A positive percentage keeps the peak output under the rail, and a negative percentage lets it run above the rail.

All voltages and the slope are unsigned fixed point with 8 integer bits and 24 fraction bits (Q8.24, so 1.0 V is 0x0100_0000).

Top module: `lim_thr_gen`

## Requirements
- R1: In tracking mode (`cfg_hdrm_en_i`=0), a supply at or above `cfg_knee_i` yields a threshold equal to `cfg_thr_max_i`, provided that the ceiling is not below the floor.
- R2: In tracking mode, a supply below the knee yields `cfg_thr_max_i` minus the drop, where the drop is the 64-bit product of `cfg_slope_i` and (knee − supply), shifted right by 24 bits (truncated). A slope of 0x0100_0000 removes 1 V of threshold per 1 V of supply drop.
- R3: In tracking mode, the threshold is never below `cfg_thr_min_i`. A result below the floor, including one where the drop exceeds the ceiling (a negative result), is replaced by `cfg_thr_min_i`.
- R4: The drop saturates at 0xFFFF_FFFF when the shifted product does not fit in 32 bits. Such a drop always forces the floor value.
- R5: In headroom mode (`cfg_hdrm_en_i`=1), the threshold is floor(supply × (100 − p) / 100). Here p is `cfg_hdrm_pct_i` read as a 5-bit two's complement percentage from −16 (5'b10000) to +15 (5'b01111). A negative p gives a threshold above the supply.
- R6: A headroom result above 0xFFFF_FFFF saturates to 0xFFFF_FFFF.
- R7: In headroom mode, the ceiling, floor, knee and slope inputs have no effect on the result.
- R8: The supply and all configuration inputs are sampled on the clock edge where `supply_vld_i` is high. `thr_vld_o` is high for exactly one cycle, three edges later, carrying that sample's result. Strobes on consecutive cycles produce results on consecutive cycles.
- R9: After reset, `thr_o` is 0 and `thr_vld_o` is 0. Between results, `thr_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_i | input | 32 | Supply sample, Q8.24 volts |
| supply_vld_i | input | 1 | Supply sample strobe |
| cfg_thr_max_i | input | 32 | Threshold ceiling, Q8.24 |
| cfg_thr_min_i | input | 32 | Threshold floor, Q8.24 |
| cfg_knee_i | input | 32 | Knee voltage where tracking starts, Q8.24 |
| cfg_slope_i | input | 32 | Tracking slope, unsigned Q8.24 V/V |
| cfg_hdrm_en_i | input | 1 | 1 selects headroom mode, 0 selects tracking mode |
| cfg_hdrm_pct_i | input | 5 | Signed headroom in 1 % steps |
| thr_o | output | 32 | Limiter threshold, Q8.24 |
| thr_vld_o | output | 1 | One-cycle flag for a new threshold |

## Verification
The embedded properties relate each stage's registered configuration to the next stage's output. They therefore assume that a whole sample, including its configuration, is consistent in the cycle of its strobe, and that nothing but the strobe advances the pipeline. The ceiling property is stated only where the ceiling is at least the floor, because with an inverted pair the floor is expected to win. The bench drives every input on the falling edge. On the cycle after each strobe, it deliberately scrambles the supply and configuration inputs, so that any late sampling would show up in the result. It keeps the table within these bounds: every row has either a proper ceiling/floor pair or is in headroom mode.

// File: rtl/lim_thr_pkg.sv
package lim_thr_pkg;

  // word and fixed-point geometry
  localparam int unsigned QW      = 32;            // voltage / slope word width
  localparam int unsigned QFRAC   = 24;            // fraction bits of Q8.24
  localparam int unsigned PCT_W   = 5;             // headroom percentage width
  localparam int unsigned FAC_W   = 7;             // width of 100 - pct (85..116)
  localparam int unsigned PROD_W  = 2 * QW;        // full slope product
  localparam int unsigned SHIFT_W = PROD_W - QFRAC;// product after realignment
  localparam int unsigned HD_W    = QW + FAC_W;    // supply * factor
  localparam int unsigned PCT_FULL = 100;          // percentage scale

  typedef logic [QW-1:0]    q_word_t;
  typedef logic [PCT_W-1:0] pct_t;
  typedef logic [FAC_W-1:0] fac_t;

  // slope * deficit, realigned to Q8.24, saturated to one word
  function automatic q_word_t q_mul_sat(input q_word_t a, input q_word_t b);
    logic [PROD_W-1:0]  prod;
    logic [SHIFT_W-1:0] aligned;
    prod    = PROD_W'(a) * PROD_W'(b);
    aligned = prod[PROD_W-1:QFRAC];
    if (|aligned[SHIFT_W-1:QW]) return '1;
    return aligned[QW-1:0];
  endfunction

  // scale factor 100 - p for a two's complement percentage p
  function automatic fac_t hdrm_factor(input pct_t p);
    logic signed [FAC_W:0] p_ext;
    logic signed [FAC_W:0] f;
    p_ext = {{(FAC_W+1-PCT_W){p[PCT_W-1]}}, p};
    f     = (FAC_W+1)'(PCT_FULL) - p_ext;
    return f[FAC_W-1:0];
  endfunction

  // floor(supply * factor / 100), saturated to one word
  function automatic q_word_t hdrm_scale(input q_word_t sup, input fac_t fac);
    logic [HD_W-1:0] prod;
    logic [HD_W-1:0] quo;
    prod = HD_W'(sup) * HD_W'(fac);
    quo  = prod / HD_W'(PCT_FULL);
    if (|quo[HD_W-1:QW]) return '1;
    return quo[QW-1:0];
  endfunction

  // tracking curve: ceiling minus drop, clamped to the floor
  function automatic q_word_t track_pick(input q_word_t mx, input q_word_t mn,
                                         input q_word_t drop);
    q_word_t t;
    if (drop > mx) return mn;          // would go negative
    t = mx - drop;
    if (t < mn) return mn;
    return t;
  endfunction

endpackage

// File: rtl/lim_thr_capture.sv
// Stage 1: sample the supply and configuration on the strobe, precompute
// the knee deficit and the headroom factor.
module lim_thr_capture
  import lim_thr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  q_word_t supply_i,
  input  logic    supply_vld_i,
  input  q_word_t thr_max_i,
  input  q_word_t thr_min_i,
  input  q_word_t knee_i,
  input  q_word_t slope_i,
  input  logic    hdrm_en_i,
  input  pct_t    hdrm_pct_i,
  output logic    s1_vld_o,
  output q_word_t s1_supply_o,
  output q_word_t s1_max_o,
  output q_word_t s1_min_o,
  output q_word_t s1_slope_o,
  output q_word_t s1_deficit_o,
  output logic    s1_above_o,
  output logic    s1_hen_o,
  output logic    s1_pct_neg_o,
  output fac_t    s1_factor_o
);

  // named intermediate results
  logic    below_knee;
  q_word_t deficit;
  fac_t    factor;

  assign below_knee = supply_i < knee_i;
  assign deficit    = below_knee ? (knee_i - supply_i) : '0;
  assign factor     = hdrm_factor(hdrm_pct_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_o <= 1'b0;
    end else begin
      s1_vld_o <= supply_vld_i;
    end
  end

  // data registers load only on a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_supply_o  <= '0;
      s1_max_o     <= '0;
      s1_min_o     <= '0;
      s1_slope_o   <= '0;
      s1_deficit_o <= '0;
      s1_above_o   <= 1'b0;
      s1_hen_o     <= 1'b0;
      s1_pct_neg_o <= 1'b0;
      s1_factor_o  <= '0;
    end else if (supply_vld_i) begin
      s1_supply_o  <= supply_i;
      s1_max_o     <= thr_max_i;
      s1_min_o     <= thr_min_i;
      s1_slope_o   <= slope_i;
      s1_deficit_o <= deficit;
      s1_above_o   <= !below_knee;
      s1_hen_o     <= hdrm_en_i;
      s1_pct_neg_o <= hdrm_pct_i[PCT_W-1];
      s1_factor_o  <= factor;
    end
  end

  // factor range for a 5-bit signed percentage is 85..116
  AST_FACTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_o |-> (s1_factor_o >= FAC_W'(85) && s1_factor_o <= FAC_W'(116))); // R5

  // a captured sample flagged above the knee has no deficit
  AST_ABOVE_NO_DEFICIT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_o && s1_above_o) |-> (s1_deficit_o == '0)); // R1

endmodule

// File: rtl/lim_thr_scale.sv
// Stage 2: the two products (tracking drop and headroom scaling).
module lim_thr_scale
  import lim_thr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s1_vld_i,
  input  q_word_t s1_supply_i,
  input  q_word_t s1_max_i,
  input  q_word_t s1_min_i,
  input  q_word_t s1_slope_i,
  input  q_word_t s1_deficit_i,
  input  logic    s1_above_i,
  input  logic    s1_hen_i,
  input  logic    s1_pct_neg_i,
  input  fac_t    s1_factor_i,
  output logic    s2_vld_o,
  output q_word_t s2_drop_o,
  output q_word_t s2_hd_o,
  output q_word_t s2_supply_o,
  output q_word_t s2_max_o,
  output q_word_t s2_min_o,
  output logic    s2_above_o,
  output logic    s2_hen_o,
  output logic    s2_pct_neg_o
);

  q_word_t drop;
  q_word_t hd;

  assign drop = q_mul_sat(s1_slope_i, s1_deficit_i);
  assign hd   = hdrm_scale(s1_supply_i, s1_factor_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_o <= 1'b0;
    end else begin
      s2_vld_o <= s1_vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_drop_o    <= '0;
      s2_hd_o      <= '0;
      s2_supply_o  <= '0;
      s2_max_o     <= '0;
      s2_min_o     <= '0;
      s2_above_o   <= 1'b0;
      s2_hen_o     <= 1'b0;
      s2_pct_neg_o <= 1'b0;
    end else if (s1_vld_i) begin
      s2_drop_o    <= drop;
      s2_hd_o      <= hd;
      s2_supply_o  <= s1_supply_i;
      s2_max_o     <= s1_max_i;
      s2_min_o     <= s1_min_i;
      s2_above_o   <= s1_above_i;
      s2_hen_o     <= s1_hen_i;
      s2_pct_neg_o <= s1_pct_neg_i;
    end
  end

  // a zero deficit can never produce a drop
  AST_NO_DEFICIT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_i && s1_deficit_i == '0) |=> (s2_drop_o == '0)); // R2

  // a zero slope can never produce a drop
  AST_ZERO_SLOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_i && s1_slope_i == '0) |=> (s2_drop_o == '0)); // R4

endmodule

// File: rtl/lim_thr_select.sv
// Stage 3: choose the curve, apply the floor, register the output.
module lim_thr_select
  import lim_thr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s2_vld_i,
  input  q_word_t s2_drop_i,
  input  q_word_t s2_hd_i,
  input  q_word_t s2_supply_i,
  input  q_word_t s2_max_i,
  input  q_word_t s2_min_i,
  input  logic    s2_above_i,
  input  logic    s2_hen_i,
  input  logic    s2_pct_neg_i,
  output q_word_t thr_o,
  output logic    thr_vld_o
);

  q_word_t track_thr;
  q_word_t next_thr;

  assign track_thr = track_pick(s2_max_i, s2_min_i, s2_drop_i);
  assign next_thr  = s2_hen_i ? s2_hd_i : track_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_vld_o <= 1'b0;
      thr_o     <= '0;
    end else begin
      thr_vld_o <= s2_vld_i;
      if (s2_vld_i) thr_o <= next_thr;
    end
  end

  AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_i && !s2_hen_i) |=> (thr_o >= $past(s2_min_i))); // R3

  AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_i && !s2_hen_i && s2_max_i >= s2_min_i) |=> (thr_o <= $past(s2_max_i))); // R2

  AST_KNEE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_i && !s2_hen_i && s2_above_i && s2_max_i >= s2_min_i)
      |=> (thr_o == $past(s2_max_i))); // R1

  AST_HDRM_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_i && s2_hen_i && !s2_pct_neg_i) |=> (thr_o <= $past(s2_supply_i))); // R5

  AST_HDRM_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_i && s2_hen_i && s2_pct_neg_i) |=> (thr_o >= $past(s2_supply_i))); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld_i |=> $stable(thr_o)); // R9

endmodule

// File: rtl/lim_thr_gen.sv
module lim_thr_gen
  import lim_thr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] supply_i,
  input  logic        supply_vld_i,
  input  logic [31:0] cfg_thr_max_i,
  input  logic [31:0] cfg_thr_min_i,
  input  logic [31:0] cfg_knee_i,
  input  logic [31:0] cfg_slope_i,
  input  logic        cfg_hdrm_en_i,
  input  logic [4:0]  cfg_hdrm_pct_i,
  output logic [31:0] thr_o,
  output logic        thr_vld_o
);

  // stage 1 -> stage 2
  logic    s1_vld;
  q_word_t s1_supply, s1_max, s1_min, s1_slope, s1_deficit;
  logic    s1_above, s1_hen, s1_pct_neg;
  fac_t    s1_factor;

  // stage 2 -> stage 3
  logic    s2_vld;
  q_word_t s2_drop, s2_hd, s2_supply, s2_max, s2_min;
  logic    s2_above, s2_hen, s2_pct_neg;

  lim_thr_capture u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_i     (supply_i),
    .supply_vld_i (supply_vld_i),
    .thr_max_i    (cfg_thr_max_i),
    .thr_min_i    (cfg_thr_min_i),
    .knee_i       (cfg_knee_i),
    .slope_i      (cfg_slope_i),
    .hdrm_en_i    (cfg_hdrm_en_i),
    .hdrm_pct_i   (cfg_hdrm_pct_i),
    .s1_vld_o     (s1_vld),
    .s1_supply_o  (s1_supply),
    .s1_max_o     (s1_max),
    .s1_min_o     (s1_min),
    .s1_slope_o   (s1_slope),
    .s1_deficit_o (s1_deficit),
    .s1_above_o   (s1_above),
    .s1_hen_o     (s1_hen),
    .s1_pct_neg_o (s1_pct_neg),
    .s1_factor_o  (s1_factor)
  );

  lim_thr_scale u_scale (
    .clk          (clk),
    .rst_n        (rst_n),
    .s1_vld_i     (s1_vld),
    .s1_supply_i  (s1_supply),
    .s1_max_i     (s1_max),
    .s1_min_i     (s1_min),
    .s1_slope_i   (s1_slope),
    .s1_deficit_i (s1_deficit),
    .s1_above_i   (s1_above),
    .s1_hen_i     (s1_hen),
    .s1_pct_neg_i (s1_pct_neg),
    .s1_factor_i  (s1_factor),
    .s2_vld_o     (s2_vld),
    .s2_drop_o    (s2_drop),
    .s2_hd_o      (s2_hd),
    .s2_supply_o  (s2_supply),
    .s2_max_o     (s2_max),
    .s2_min_o     (s2_min),
    .s2_above_o   (s2_above),
    .s2_hen_o     (s2_hen),
    .s2_pct_neg_o (s2_pct_neg)
  );

  lim_thr_select u_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .s2_vld_i     (s2_vld),
    .s2_drop_i    (s2_drop),
    .s2_hd_i      (s2_hd),
    .s2_supply_i  (s2_supply),
    .s2_max_i     (s2_max),
    .s2_min_i     (s2_min),
    .s2_above_i   (s2_above),
    .s2_hen_i     (s2_hen),
    .s2_pct_neg_i (s2_pct_neg),
    .thr_o        (thr_o),
    .thr_vld_o    (thr_vld_o)
  );

  // strobe advances one stage per edge across module boundaries
  AST_STAGE1_TO_2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> s2_vld); // R8
  AST_STAGE2_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |=> thr_vld_o); // R8
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> !thr_vld_o); // R8

endmodule

// File: tb/test_lim_thr_gen.sv
module test_lim_thr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] supply_i = '0;
  logic        supply_vld_i = 1'b0;
  logic [31:0] cfg_thr_max_i = '0;
  logic [31:0] cfg_thr_min_i = '0;
  logic [31:0] cfg_knee_i = '0;
  logic [31:0] cfg_slope_i = '0;
  logic        cfg_hdrm_en_i = 1'b0;
  logic [4:0]  cfg_hdrm_pct_i = '0;
  logic [31:0] thr_o;
  logic        thr_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lim_thr_gen i_lim_thr_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_i       (supply_i),
    .supply_vld_i   (supply_vld_i),
    .cfg_thr_max_i  (cfg_thr_max_i),
    .cfg_thr_min_i  (cfg_thr_min_i),
    .cfg_knee_i     (cfg_knee_i),
    .cfg_slope_i    (cfg_slope_i),
    .cfg_hdrm_en_i  (cfg_hdrm_en_i),
    .cfg_hdrm_pct_i (cfg_hdrm_pct_i),
    .thr_o          (thr_o),
    .thr_vld_o      (thr_vld_o)
  );

  typedef struct packed {
    logic [31:0] sup;
    logic [31:0] mx;
    logic [31:0] mn;
    logic [31:0] knee;
    logic [31:0] slope;
    logic        hen;
    logic [4:0]  pct;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  // Q8.24: 1 V = 0x0100_0000
  localparam vec_t VECS [NV] = '{
    // tracking: ceiling 5 V, floor 2 V, knee 4 V
    '{32'h0600_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b0, 5'd0, 32'h0500_0000, 8'd1}, // R1 above knee
    '{32'h0400_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b0, 5'd0, 32'h0500_0000, 8'd1}, // R1 exactly at knee
    '{32'h0380_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b0, 5'd0, 32'h0480_0000, 8'd2}, // R2 slope 1
    '{32'h0300_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0200_0000, 1'b0, 5'd0, 32'h0300_0000, 8'd2}, // R2 slope 2
    '{32'h0300_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0080_0000, 1'b0, 5'd0, 32'h0480_0000, 8'd2}, // R2 slope 0.5
    '{32'h03FF_FFFF, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0180_0000, 1'b0, 5'd0, 32'h04FF_FFFF, 8'd2}, // R2 truncation 1 lsb
    '{32'h03FF_FFFF, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0080_0000, 1'b0, 5'd0, 32'h0500_0000, 8'd2}, // R2 truncates to 0
    '{32'h0100_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b0, 5'd0, 32'h0200_0000, 8'd3}, // R3 lands on floor
    '{32'h0080_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b0, 5'd0, 32'h0200_0000, 8'd3}, // R3 under floor
    '{32'h0000_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0200_0000, 1'b0, 5'd0, 32'h0200_0000, 8'd3}, // R3 negative
    '{32'h0000_0000, 32'h0500_0000, 32'h0200_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0, 32'h0200_0000, 8'd4}, // R4 drop saturates
    // headroom
    '{32'h0500_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b1, 5'b01010, 32'h0480_0000, 8'd5}, // R5 +10 %
    '{32'h0500_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b1, 5'b10110, 32'h0580_0000, 8'd5}, // R5 -10 %
    '{32'h0500_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b1, 5'b10000, 32'h05CC_CCCC, 8'd5}, // R5 -16 %
    '{32'h0300_0000, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b1, 5'b01111, 32'h028C_CCCC, 8'd5}, // R5 +15 %
    '{32'hFFFF_FFFF, 32'h0500_0000, 32'h0200_0000, 32'h0400_0000, 32'h0100_0000, 1'b1, 5'b10000, 32'hFFFF_FFFF, 8'd6}, // R6 saturation
    '{32'h0500_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd0,     32'h0500_0000, 8'd7}  // R7 curve inputs ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    supply_i       = v.sup;
    cfg_thr_max_i  = v.mx;
    cfg_thr_min_i  = v.mn;
    cfg_knee_i     = v.knee;
    cfg_slope_i    = v.slope;
    cfg_hdrm_en_i  = v.hen;
    cfg_hdrm_pct_i = v.pct;
  endtask

  // scramble after the strobe edge: late sampling would corrupt the result (R8)
  task automatic scramble();
    supply_i       = 32'h1234_5678;
    cfg_thr_max_i  = 32'h0000_0001;
    cfg_thr_min_i  = 32'h7F00_0000;
    cfg_knee_i     = 32'h0000_0000;
    cfg_slope_i    = 32'h0000_0000;
    cfg_hdrm_en_i  = ~cfg_hdrm_en_i;
    cfg_hdrm_pct_i = 5'b10101;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 reset thr", thr_o, 32'h0);
    check("R9 reset vld", {31'b0, thr_vld_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      supply_vld_i = 1'b1;
      @(negedge clk);                 // after capture edge
      supply_vld_i = 1'b0;
      scramble();
      check($sformatf("R8 no early vld row %0d", i), {31'b0, thr_vld_o}, 32'h0);
      @(negedge clk);
      @(negedge clk);                 // three edges after strobe
      check($sformatf("R8 vld row %0d", i), {31'b0, thr_vld_o}, 32'h1);
      check($sformatf("R%0d row %0d", VECS[i].req, i), thr_o, VECS[i].exp);
      held = thr_o;
      @(negedge clk);
      check($sformatf("R9 vld drops row %0d", i), {31'b0, thr_vld_o}, 32'h0);
      check($sformatf("R9 hold row %0d", i), thr_o, held);
    end

    // R8 back-to-back strobes: rows 2 then 12
    drive(VECS[2]);
    supply_vld_i = 1'b1;
    @(negedge clk);
    drive(VECS[12]);
    @(negedge clk);
    supply_vld_i = 1'b0;
    scramble();
    @(negedge clk);
    check("R8 b2b first vld", {31'b0, thr_vld_o}, 32'h1);
    check("R8 b2b first", thr_o, VECS[2].exp);
    @(negedge clk);
    check("R8 b2b second vld", {31'b0, thr_vld_o}, 32'h1);
    check("R8 b2b second", thr_o, VECS[12].exp);
    @(negedge clk);
    check("R8 b2b end vld", {31'b0, thr_vld_o}, 32'h0);

    // R9 long idle: output holds
    held = thr_o;
    repeat (10) @(negedge clk);
    check("R9 idle hold", thr_o, held);

    // R3 inverted pair: floor above ceiling, supply above knee -> floor
    drive('{32'h0600_0000, 32'h0200_0000, 32'h0300_0000, 32'h0400_0000, 32'h0100_0000,
            1'b0, 5'd0, 32'h0, 8'd3});
    supply_vld_i = 1'b1;
    @(negedge clk);
    supply_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 floor over ceiling", thr_o, 32'h0300_0000);

    // R9 reset mid-stream clears output
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset thr", thr_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule